// File: doc/BRIEF.md
# ISA bus cycle wait-state controller

This block times a single ISA bus cycle in bus clocks and decides when the command strobe ends. A requester pulses a start input with the cycle kind (memory, I/O or DMA) and the state of the four size-acknowledge lines. The controller drives the command strobe for a number of bus clocks. That number comes from three sources. The first is a default length per cycle kind and slave width. The second is the slave holding the ready line low, which stretches the cycle. The third is the slave raising the zero-wait-state line, which shortens it.

A slave is 16-bit when any size-acknowledge line is asserted and 8-bit otherwise. The kind and width are latched when a start request is accepted. The ready line, the extra ready line and the zero-wait-state line are sampled on each clock edge that ends a command clock. A one-clock done pulse marks the end of the cycle. An optional watchdog ends a cycle that is stretched too long and sets a sticky error flag.

Top module: `isa_wait_ctl`

## Requirements
- R1: After reset, cmd_o, busy_o, done_o and tmo_err_o are all low.
- R2: A start_i sampled high while busy_o is low raises cmd_o and busy_o on that same clock edge. Command clock 1 is the clock that follows that edge.
- R3: cyc_type_i is decoded as 00 = memory, 01 = I/O, 1x = DMA. The slave is 16-bit when any bit of size_ack_i is 1. Default lengths in command clocks are 6 for an 8-bit slave (memory or I/O), 3 for a 16-bit memory slave, 3 for a 16-bit I/O slave and 4 for DMA.
- R4: With zws_i high and the ready lines high, an 8-bit memory or I/O cycle lasts 3 command clocks and a 16-bit memory cycle lasts 2.
- R5: zws_i has no effect on 16-bit I/O cycles or on DMA cycles.
- R6: While rdy_i is sampled low, the cycle does not end. It ends at the first sampling edge with rdy_i high once its length has been reached. This applies to every cycle kind, DMA included.
- R7: When zws_i is high while rdy_i is low, the shortening is not applied and the cycle keeps stretching.
- R8: xrdy_i low stretches a cycle in the same way as rdy_i low, but only for 8-bit slaves. It has no effect on 16-bit slaves.
- R9: cmd_o falls on the same edge that raises done_o. done_o stays high for exactly one clock, and busy_o stays high through that clock.
- R10: A start_i request made while busy_o is high, including during the done clock, is ignored.
- R11: A cycle still stretched at TMO_CYCLES (default 32) command clocks ends there and sets tmo_err_o. tmo_err_o then stays high until reset.
- R12: Every cycle has at least two command clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run one bus cycle |
| cyc_type_i | input | 2 | Cycle kind: 00 memory, 01 I/O, 1x DMA |
| size_ack_i | input | 4 | Size-acknowledge lines, active high; any set means a 16-bit slave |
| rdy_i | input | 1 | Ready line, active high; low stretches the cycle |
| xrdy_i | input | 1 | Extra ready line, active high; low stretches 8-bit cycles only |
| zws_i | input | 1 | Zero-wait-state request, active high |
| cmd_o | output | 1 | Command strobe, active high |
| busy_o | output | 1 | High from acceptance through the done clock |
| done_o | output | 1 | One-clock pulse at the end of the cycle |
| tmo_err_o | output | 1 | Sticky stretch-timeout flag |

## Verification
The hardest case to reach is a cycle where the zero-wait-state request and a low ready line overlap. The length must then come from the ready release, not from the shortened count. An extra ready line that is held low on a 16-bit slave must also leave the length unchanged. The bench drives each line as a function of the command clock number it is currently in. It sweeps the release clock of each ready line across, before and past the default length, for every kind, size-acknowledge pattern and zero-wait setting. The timeout is reached by holding ready low beyond the limit, and a last cycle checks that the error flag stays set.

// File: rtl/isa_wait_pkg.sv
package isa_wait_pkg;
  typedef enum logic [1:0] {
    CYC_MEM  = 2'b00,
    CYC_IO   = 2'b01,
    CYC_DMA  = 2'b10,
    CYC_DMA2 = 2'b11
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CMD  = 2'b01,
    ST_DONE = 2'b10
  } seq_state_e;
endpackage

// File: rtl/isa_len_sel.sv
module isa_len_sel
  import isa_wait_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int LEN8_DEF     = 6,
  parameter int LEN8_SHORT   = 3,
  parameter int LEN16M_DEF   = 3,
  parameter int LEN16M_SHORT = 2,
  parameter int LEN16IO_DEF  = 3,
  parameter int LENDMA_DEF   = 4
) (
  input  cyc_kind_e          kind_i,
  input  logic               wide_i,
  output logic [CNT_W-1:0]   def_len_o,
  output logic [CNT_W-1:0]   short_len_o,
  output logic               short_ok_o
);
  always_comb begin
    def_len_o   = CNT_W'(LEN8_DEF);
    short_len_o = CNT_W'(LEN8_SHORT);
    short_ok_o  = 1'b1;
    unique case (kind_i)
      CYC_MEM: begin
        if (wide_i) begin
          def_len_o   = CNT_W'(LEN16M_DEF);
          short_len_o = CNT_W'(LEN16M_SHORT);
        end
      end
      CYC_IO: begin
        if (wide_i) begin
          def_len_o   = CNT_W'(LEN16IO_DEF);
          short_len_o = CNT_W'(LEN16IO_DEF);
          short_ok_o  = 1'b0;
        end
      end
      default: begin
        def_len_o   = CNT_W'(LENDMA_DEF);
        short_len_o = CNT_W'(LENDMA_DEF);
        short_ok_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/isa_line_merge.sv
module isa_line_merge (
  input  logic rdy_i,
  input  logic xrdy_i,
  input  logic zws_i,
  input  logic wide_i,
  input  logic short_ok_i,
  output logic hold_o,
  output logic shorten_o
);
  logic xhold;

  always_comb begin
    xhold     = ~wide_i & ~xrdy_i;
    hold_o    = ~rdy_i | xhold;
    shorten_o = zws_i & short_ok_i & ~hold_o;
  end
endmodule

// File: rtl/isa_cyc_seq.sv
module isa_cyc_seq
  import isa_wait_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter bit TMO_EN     = 1'b1,
  parameter int TMO_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hold_i,
  input  logic             shorten_i,
  input  logic [CNT_W-1:0] def_len_i,
  input  logic [CNT_W-1:0] short_len_i,
  output logic             cmd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             tmo_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             tmo_hit, len_ok, norm_end, fin;

  generate
    if (TMO_EN) begin : g_tmo
      assign tmo_hit = (cnt_q >= CNT_W'(TMO_CYCLES));
    end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    len_ok   = (cnt_q >= def_len_i) | (shorten_i & (cnt_q >= short_len_i));
    norm_end = (cnt_q >= CNT_TWO) & ~hold_i & len_ok;
    fin      = norm_end | ((cnt_q >= CNT_TWO) & tmo_hit);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CMD;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_CMD: begin
        if (fin) begin
          state_d = ST_DONE;
          cnt_d   = '0;
          if (!norm_end) err_d = 1'b1;
        end else if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign cmd_o     = (state_q == ST_CMD);
  assign done_o    = (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);
  assign tmo_err_o = err_q;
endmodule

// File: rtl/isa_wait_ctl.sv
module isa_wait_ctl
  import isa_wait_pkg::*;
#(
  parameter int ACK_W        = 4,
  parameter int LEN8_DEF     = 6,
  parameter int LEN8_SHORT   = 3,
  parameter int LEN16M_DEF   = 3,
  parameter int LEN16M_SHORT = 2,
  parameter int LEN16IO_DEF  = 3,
  parameter int LENDMA_DEF   = 4,
  parameter bit TMO_EN       = 1'b1,
  parameter int TMO_CYCLES   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       cyc_type_i,
  input  logic [ACK_W-1:0] size_ack_i,
  input  logic             rdy_i,
  input  logic             xrdy_i,
  input  logic             zws_i,
  output logic             cmd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             tmo_err_o
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1) + 1;

  logic       rst_meta_q, rst_s_n;
  cyc_kind_e  kind_q, kind_d;
  logic       wide_q, wide_d;
  logic       take;
  logic [CNT_W-1:0] def_len, short_len;
  logic       short_ok, hold, shorten;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  always_comb begin
    take   = start_i & ~busy_o;
    kind_d = take ? cyc_kind_e'(cyc_type_i) : kind_q;
    wide_d = take ? (|size_ack_i)           : wide_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      kind_q <= CYC_MEM;
      wide_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      wide_q <= wide_d;
    end
  end

  isa_len_sel #(
    .CNT_W(CNT_W), .LEN8_DEF(LEN8_DEF), .LEN8_SHORT(LEN8_SHORT),
    .LEN16M_DEF(LEN16M_DEF), .LEN16M_SHORT(LEN16M_SHORT),
    .LEN16IO_DEF(LEN16IO_DEF), .LENDMA_DEF(LENDMA_DEF)
  ) u_len (
    .kind_i(kind_q), .wide_i(wide_q),
    .def_len_o(def_len), .short_len_o(short_len), .short_ok_o(short_ok)
  );

  isa_line_merge u_lines (
    .rdy_i(rdy_i), .xrdy_i(xrdy_i), .zws_i(zws_i), .wide_i(wide_q),
    .short_ok_i(short_ok), .hold_o(hold), .shorten_o(shorten)
  );

  isa_cyc_seq #(
    .CNT_W(CNT_W), .TMO_EN(TMO_EN), .TMO_CYCLES(TMO_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_s_n), .start_i(start_i),
    .hold_i(hold), .shorten_i(shorten),
    .def_len_i(def_len), .short_len_i(short_len),
    .cmd_o(cmd_o), .busy_o(busy_o), .done_o(done_o), .tmo_err_o(tmo_err_o)
  );
endmodule

// File: rtl/isa_wait_ctl_chk.sv
module isa_wait_ctl_chk #(
  parameter int TMO_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic rdy_i,
  input logic cmd_o,
  input logic busy_o,
  input logic done_o,
  input logic tmo_err_o
);
  logic [15:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ck_cnt <= '0;
    else if (cmd_o)  ck_cnt <= ck_cnt + 16'd1;
    else             ck_cnt <= '0;
  end

  // R9: done lasts one clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: strobe end coincides with done
  a_r9_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_o) |-> done_o && busy_o);
  // R12: at least two command clocks
  a_r12_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_o) |=> cmd_o);
  // R10: no restart straight out of the done clock
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !cmd_o);
  // R6: low ready holds the strobe unless the timeout is due
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o && !rdy_i && (ck_cnt + 16'd1 < 16'(TMO_CYCLES))) |=> cmd_o);
  // R11: error is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |=> tmo_err_o);
  // R11: error only rises when a cycle ends
  a_r11_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> $fell(cmd_o));
endmodule

bind isa_wait_ctl isa_wait_ctl_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .rdy_i(rdy_i), .cmd_o(cmd_o),
  .busy_o(busy_o), .done_o(done_o), .tmo_err_o(tmo_err_o)
);

// File: tb/test_isa_wait_ctl.sv
module test_isa_wait_ctl;
  localparam int TMO = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] cyc_type_i;
  logic [3:0] size_ack_i;
  logic       rdy_i, xrdy_i, zws_i;
  logic       cmd_o, busy_o, done_o, tmo_err_o;

  int total = 0;
  int bad   = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  isa_wait_ctl #(.TMO_CYCLES(TMO)) i_isa_wait_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cyc_type_i(cyc_type_i),
    .size_ack_i(size_ack_i), .rdy_i(rdy_i), .xrdy_i(xrdy_i), .zws_i(zws_i),
    .cmd_o(cmd_o), .busy_o(busy_o), .done_o(done_o), .tmo_err_o(tmo_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] t, input logic [3:0] a,
                                 input bit z, input int rl, input int xl);
    bit wide, dma, sok;
    int dl, sl, base, reff, l;
    wide = |a;
    dma  = t[1];
    dl   = dma ? 4 : (wide ? 3 : 6);
    sl   = wide ? 2 : 3;
    sok  = !dma && (!wide || t == 2'b00);
    base = (z && sok) ? sl : dl;
    reff = wide ? rl : ((xl > rl) ? xl : rl);
    l    = (base > reff + 1) ? base : reff + 1;
    if (l > TMO) l = TMO;
    return l;
  endfunction

  function automatic string tag_of(input logic [1:0] t, input logic [3:0] a,
                                   input bit z, input int rl, input int xl);
    bit wide, sok;
    wide = |a;
    sok  = !t[1] && (!wide || t == 2'b00);
    if (rl >= TMO)          return "R11";
    if (xl > 0)             return "R8";
    if (rl > 0 && z)        return "R7";
    if (rl > 0)             return "R6";
    if (z && sok)           return "R4";
    if (z)                  return "R5";
    return "R3";
  endfunction

  task automatic run_cyc(input logic [1:0] t, input logic [3:0] a, input bit z,
                         input int rl, input int xl, input bit keep);
    int k;
    int e;
    string tg;
    e  = exp_len(t, a, z, rl, xl);
    tg = tag_of(t, a, z, rl, xl);
    @(negedge clk);
    cyc_type_i = t; size_ack_i = a; zws_i = z; start_i = 1'b1;
    rdy_i = (1 > rl); xrdy_i = (1 > xl);
    @(posedge clk);
    @(negedge clk);
    if (!keep) start_i = 1'b0;
    chk(cmd_o && busy_o && !done_o, "R2", {29'd0, cmd_o, busy_o, done_o}, 6);
    k = 1;
    while (cmd_o && k < 100) begin
      rdy_i  = (k > rl);
      xrdy_i = (k > xl);
      @(posedge clk);
      @(negedge clk);
      if (cmd_o) k++;
    end
    rdy_i = 1'b1; xrdy_i = 1'b1;
    chk(k == e, tg, k, e);
    chk(done_o && busy_o, "R9", {30'd0, done_o, busy_o}, 3);
    @(posedge clk);
    @(negedge clk);
    chk(!done_o && !busy_o && !cmd_o, "R9", {29'd0, done_o, busy_o, cmd_o}, 0);
    if (keep) begin
      start_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(!cmd_o && !busy_o, "R10", {30'd0, cmd_o, busy_o}, 0);
    end
  endtask

  initial begin
    #1_500_000;
    wd_hit = 1'b1;
  end

  initial begin : main
    rst_n = 1'b0; start_i = 1'b0; cyc_type_i = 2'b00; size_ack_i = 4'h0;
    rdy_i = 1'b1; xrdy_i = 1'b1; zws_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!cmd_o && !busy_o && !done_o && !tmo_err_o, "R1",
        {28'd0, cmd_o, busy_o, done_o, tmo_err_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cmd_o && !busy_o && !done_o && !tmo_err_o, "R1",
        {28'd0, cmd_o, busy_o, done_o, tmo_err_o}, 0);

    fork
      begin
        for (int t = 0; t < 4; t++)
          for (int a = 0; a < 16; a++)
            for (int z = 0; z < 2; z++)
              for (int rl = 0; rl < 8; rl++)
                for (int xs = 0; xs < 2; xs++)
                  run_cyc(2'(t), 4'(a), z[0], rl, xs * 5, (rl == 3));
        chk(!tmo_err_o, "R11", {31'd0, tmo_err_o}, 0);
        run_cyc(2'b00, 4'h4, 1'b1, 40, 0, 1'b0);
        chk(tmo_err_o, "R11", {31'd0, tmo_err_o}, 1);
        run_cyc(2'b01, 4'h0, 1'b0, 0, 0, 1'b0);
        chk(tmo_err_o, "R11", {31'd0, tmo_err_o}, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!tmo_err_o && !busy_o, "R1", {30'd0, tmo_err_o, busy_o}, 0);
        rst_n = 1'b1;
      end
      begin
        wait (wd_hit);
      end
    join_any
    if (wd_hit) chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule